// File: doc/BRIEF.md
# Modem Line Status Tracker

This block holds the modem control byte and the modem status byte of a classic byte-wide serial port. It watches four incoming handshake lines: clear-to-send, data-set-ready, ring and carrier detect. It resynchronises them to the local clock and keeps the most recent level of each line. It also records in four sticky change flags that a line has moved since software last looked. When the modem-status interrupt enable is set and any change flag is raised, the block requests an interrupt. The interrupt controller that merges this request with the other sources sits outside the block.

Software reaches three registers through a byte-wide port with a two-bit address: the interrupt enable at 0, modem control at 1 and modem status at 2. A read strobe on the status address acknowledges the change flags. Setting the loopback bit in the control byte makes the status byte mirror the four control outputs, so a driver can test its handshake logic without a cable.

Top module: `modem_status_unit`

## Requirements
- R1: The status byte holds carrier at bit 7, ring at bit 6, data-set-ready at bit 5 and clear-to-send at bit 4. When the stored level of carrier, data-set-ready or clear-to-send changes, the flag at bit 3, bit 1 or bit 0 respectively is set. Each flag is the XOR of the old and new level of its line.
- R2: A change flag that is set stays set when more lines change or when a line returns to its earlier level. Only an acknowledging read clears it.
- R3: The ring flag (bit 2) is set only when the ring level falls from 1 to 0. A rise from 0 to 1 leaves the flag unchanged.
- R4: A read strobe at address 2 returns the full status byte in that cycle and clears bits 3:0 at the next clock edge. A change that is recorded on that same edge is kept.
- R5: When control bit 4 is set, the status read returns OUT2 (control bit 3) as carrier, OUT1 (bit 2) as ring, RTS (bit 1) as clear-to-send and DTR (bit 0) as data-set-ready. Bits 3:0 read as 0, and a status read does not clear the stored flags.
- R6: A write to address 1 keeps only data bits 4:0. The control byte resets to 0x08. The outputs dtr_o, rts_o, aux1_o and aux2_o follow control bits 0, 1, 2 and 3.
- R7: After reset the status byte reads 0xB0 and irq_o is low.
- R8: irq_o is high exactly when the enable bit is set and any stored change flag is 1. The enable bit is bit 3 of address 0, and the other bits of that register are not stored and read as 0.
- R9: A change on an input line first shows in the status byte after the third rising clock edge that follows it.
- R10: Writes to address 2 have no effect. Address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (acts at address 2) |
| addr | input | 2 | Register select: 0 enable, 1 control, 2 status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| cts_i | input | 1 | Clear-to-send line |
| dsr_i | input | 1 | Data-set-ready line |
| ri_i | input | 1 | Ring line |
| dcd_i | input | 1 | Carrier-detect line |
| dtr_o | output | 1 | DTR output (control bit 0) |
| rts_o | output | 1 | RTS output (control bit 1) |
| aux1_o | output | 1 | OUT1 output (control bit 2) |
| aux2_o | output | 1 | OUT2 output (control bit 3) |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
The hardest case to reach is a line change that lands in the status register on the same edge as an acknowledging read. The flags from before the read must clear while the new flag survives. The stimulus creates this by raising one flag first. It then changes a second line and, counting the synchroniser delay, asserts the read strobe in the cycle just before that change arrives. The loopback case is also driven with change flags already pending, to show that they are hidden in that mode, that a read there does not consume them, and that they return when loopback ends.

// File: rtl/modem_status_unit.sv
`timescale 1ns/1ps
module modem_status_unit #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       cts_i,
  input  logic       dsr_i,
  input  logic       ri_i,
  input  logic       dcd_i,
  output logic       dtr_o,
  output logic       rts_o,
  output logic       aux1_o,
  output logic       aux2_o,
  output logic       irq_o
);
  localparam logic [3:0] LINE_RST = 4'b1011;
  localparam logic [3:0] XOR_MASK = 4'b1011;
  localparam logic [4:0] CTL_RST  = 5'h08;

  logic [3:0] sync_q [SYNC_STAGES];
  logic [3:0] sampled, stat, delta, chg;
  logic [4:0] mcr;
  logic       ien;
  wire        loop = mcr[4];
  wire  [3:0] lines = {dcd_i, ri_i, dsr_i, cts_i};
  wire        ack = rd_en && addr == 2'd2 && !loop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= LINE_RST;
    end else begin
      sync_q[0] <= lines;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign sampled = sync_q[SYNC_STAGES-1];
  assign chg = ((stat ^ sampled) & XOR_MASK) | {1'b0, stat[2] & ~sampled[2], 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat  <= LINE_RST;
      delta <= '0;
      mcr   <= CTL_RST;
      ien   <= 1'b0;
    end else begin
      stat  <= sampled;
      delta <= (ack ? 4'b0000 : delta) | chg;
      if (wr_en && addr == 2'd1) mcr <= wdata[4:0];
      if (wr_en && addr == 2'd0) ien <= wdata[3];
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = {4'b0000, ien, 3'b000};
      2'd1:    rdata = {3'b000, mcr};
      2'd2:    rdata = loop ? {mcr[3], mcr[2], mcr[0], mcr[1], 4'b0000} : {stat, delta};
      default: rdata = 8'h00;
    endcase
  end

  assign irq_o  = ien & |delta;
  assign dtr_o  = mcr[0];
  assign rts_o  = mcr[1];
  assign aux1_o = mcr[2];
  assign aux2_o = mcr[3];
endmodule

module modem_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_en,
  input logic [1:0] addr,
  input logic [7:0] rdata,
  input logic       irq_o,
  input logic       ien,
  input logic [4:0] mcr,
  input logic [3:0] stat,
  input logic [3:0] delta,
  input logic [3:0] sampled
);
  // R1
  change_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((stat ^ sampled) & 4'b1011) != 4'b0000) |=> ((delta & 4'b1011) != 4'b0000));
  // R2
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && addr == 2'd2 && !mcr[4]) |=> ((delta & $past(delta)) == $past(delta)));
  // R3
  ring_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat[2] && sampled[2] && !delta[2]) |=> !delta[2]);
  // R4
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd2 && !mcr[4] && stat == sampled) |=> (delta == 4'b0000));
  // R5
  loop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mcr[4] && addr == 2'd2) |-> (rdata[3:0] == 4'b0000));
  // R6
  ctl_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd1) |-> (rdata[7:5] == 3'b000));
  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien || delta == 4'b0000) |-> !irq_o);
endmodule

bind modem_status_unit modem_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .irq_o(irq_o), .ien(ien), .mcr(mcr), .stat(stat), .delta(delta),
  .sampled(sampled)
);

// File: tb/tb_modem_status_unit.sv
`timescale 1ns/1ps
module tb_modem_status_unit;
  localparam int SYNC = 2;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic cts_i = 1, dsr_i = 1, ri_i = 0, dcd_i = 1;
  logic dtr_o, rts_o, aux1_o, aux2_o, irq_o;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  modem_status_unit #(.SYNC_STAGES(SYNC)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cts_i(cts_i), .dsr_i(dsr_i), .ri_i(ri_i),
    .dcd_i(dcd_i), .dtr_o(dtr_o), .rts_o(rts_o), .aux1_o(aux1_o),
    .aux2_o(aux2_o), .irq_o(irq_o)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference
  logic [3:0] pipe[$];
  logic [3:0] m_stat, m_delta, v, c;
  logic [4:0] m_ctl;
  logic m_en;

  function automatic logic [7:0] exp_rd();
    case (addr)
      2'd0: return {4'b0, m_en, 3'b0};
      2'd1: return {3'b0, m_ctl};
      2'd2: return m_ctl[4] ? {m_ctl[3], m_ctl[2], m_ctl[0], m_ctl[1], 4'b0} : {m_stat, m_delta};
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      pipe.delete();
      for (int i = 0; i < SYNC; i++) pipe.push_back(4'b1011);
      m_stat = 4'b1011; m_delta = 0; m_ctl = 5'h08; m_en = 0;
    end else begin
      v = pipe.pop_front();
      pipe.push_back({dcd_i, ri_i, dsr_i, cts_i});
      c = 0;
      if (v[3] != m_stat[3]) c[3] = 1;
      if (v[1] != m_stat[1]) c[1] = 1;
      if (v[0] != m_stat[0]) c[0] = 1;
      if (m_stat[2] == 1 && v[2] == 0) c[2] = 1;
      if (rd_en && addr == 2 && !m_ctl[4]) m_delta = 0;
      m_delta = m_delta | c;
      m_stat = v;
      if (wr_en && addr == 1) m_ctl = wdata[4:0];
      if (wr_en && addr == 0) m_en = wdata[3];
      #2;
      if (!done) begin
        check("R1/R9 model rdata", rdata, exp_rd());
        check("R8 model irq", {7'b0, irq_o}, {7'b0, m_en && m_delta != 0});
        check("R6 model outputs", {4'b0, aux2_o, aux1_o, rts_o, dtr_o}, {4'b0, m_ctl[3:0]});
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic peek(input logic [1:0] a, string tag, input logic [7:0] exp);
    addr = a; #1; check(tag, rdata, exp);
  endtask

  task automatic ack(string tag, input logic [7:0] exp);
    @(negedge clk); addr = 2; rd_en = 1; #1; check(tag, rdata, exp);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    waitn(3); rst_n = 1; waitn(1);
    peek(2, "R7 reset status", 8'hB0);
    peek(1, "R6 reset control", 8'h08);
    check("R7 reset irq", {7'b0, irq_o}, 8'h00);
    check("R6 reset aux2", {7'b0, aux2_o}, 8'h01);
    // R1 / R9: clear-to-send falls
    @(negedge clk); cts_i = 0;
    waitn(2); peek(2, "R9 not yet visible", 8'hB0);
    waitn(1); peek(2, "R1 cts change", 8'hA1);
    check("R8 irq masked", {7'b0, irq_o}, 8'h00);
    // R8: only bit 3 of enable kept
    wr(0, 8'hFF); peek(0, "R8 enable readback", 8'h08);
    check("R8 irq raised", {7'b0, irq_o}, 8'h01);
    // R2: sticky across further changes
    @(negedge clk); dsr_i = 0; waitn(3);
    peek(2, "R2 flags accumulate", 8'h83);
    // R4: acknowledge
    ack("R4 read returns value", 8'h83);
    peek(2, "R4 flags cleared", 8'h80);
    check("R8 irq dropped", {7'b0, irq_o}, 8'h00);
    // R3: ring edges
    @(negedge clk); ri_i = 1; waitn(3); peek(2, "R3 ring rise no flag", 8'hC0);
    @(negedge clk); ri_i = 0; waitn(3); peek(2, "R3 ring fall flag", 8'h84);
    ack("R3 ack", 8'h84);
    // R4: change landing on the acknowledge edge
    @(negedge clk); dcd_i = 0; waitn(3); peek(2, "R1 carrier change", 8'h08);
    @(negedge clk); cts_i = 1;
    @(negedge clk);
    @(negedge clk); addr = 2; rd_en = 1; #1; check("R4 same-edge read", rdata, 8'h08);
    @(negedge clk); rd_en = 0; #1; check("R4 new change kept", rdata, 8'h11);
    ack("R4 ack", 8'h11);
    // R5: loopback with a pending flag
    @(negedge clk); dsr_i = 1; waitn(3); peek(2, "R1 dsr rise", 8'h32);
    wr(1, 8'h1F); peek(2, "R5 loop all", 8'hF0);
    check("R8 irq in loop", {7'b0, irq_o}, 8'h01);
    ack("R5 loop read", 8'hF0);
    wr(1, 8'h11); peek(2, "R5 dtr to dsr", 8'h20);
    wr(1, 8'h12); peek(2, "R5 rts to cts", 8'h10);
    wr(1, 8'h14); peek(2, "R5 out1 to ring", 8'h40);
    wr(1, 8'h18); peek(2, "R5 out2 to carrier", 8'h80);
    wr(1, 8'h08); peek(2, "R5 flags survive loop", 8'h32);
    // R6: control width and outputs
    wr(1, 8'hFF); peek(1, "R6 low five bits", 8'h1F);
    wr(1, 8'hE5); peek(1, "R6 masked write", 8'h05);
    check("R6 outputs", {4'b0, aux2_o, aux1_o, rts_o, dtr_o}, 8'h05);
    // R10: status write ignored, address 3 empty
    wr(2, 8'h00); peek(2, "R10 status write ignored", 8'h32);
    peek(3, "R10 unused address", 8'h00);
    ack("R4 final ack", 8'h32);
    peek(2, "R4 final clear", 8'h30);
    waitn(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule